// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counters

This block holds the time and date of a real-time clock as packed BCD registers: seconds, minutes, hours in 24-hour form, day of week, day of month, month, a two-digit year and a century bit. Each pulse on the one-second tick input advances the seconds. Carries ripple up through minutes, hours, day of week, date, month and year in the same clock cycle. The length of the month, including February in leap years, comes from the current month and year registers.

A host writes whole bytes to any of the seven registers through a valid/ready write port. The port never applies back-pressure: `wr_ready` is always 1, so every cycle with `wr_valid` high commits one byte. A write on the same cycle as a tick replaces the written register's next value. Separately, an oscillator monitor watches a per-cycle pulse-present input. It raises a sticky failure flag in the top bit of the minutes register, and only the host can clear that flag.

Register map (addresses on `wr_addr`): 0 seconds {halt, sec[6:0]}; 1 minutes {osc_fail, min[6:0]}; 2 hours {cent_en, cent, hour[5:0]}; 3 day of week [2:0]; 4 date [5:0]; 5 month [4:0]; 6 year [7:0]. Address 7 is unused.

Top module: `rtc_calendar_core`

## Requirements
- R1: When `tick_1hz` is high and the halt bit (seconds bit 7) is 0, seconds count 00..59 in BCD. At 59 they return to 00 and advance minutes. Minutes likewise count 00..59 and advance hours. Hours count 00..23 and advance both day of week and date.
- R2: Day of week counts 1..7. At 7 or above it returns to 1. A written 0 advances to 1 on the next hour rollover.
- R3: Date counts from 01 up to the month length, then returns to 01 and advances the month. The month length is 29 for month 02 when the year value (tens*10+ones) is divisible by 4 and 28 otherwise, 30 for months 04, 06, 09 and 11, and 31 for every other month code. Month counts 01..12, then returns to 01 and advances the year.
- R4: Year counts 00..99 and returns to 00. On that wrap, the century bit (hours bit 6) toggles only if century enable (hours bit 7) is 1. Otherwise it is unchanged.
- R5: A field whose raw value is at or above its maximum rolls over to its minimum on the next advance, with a carry. Otherwise, a low digit of 9 or above becomes 0 and the tens digit increments, and any other low digit increments. Written invalid codes are therefore kept and counted from as written.
- R6: While the halt bit is 1, ticks have no effect on any time or date field. Writing the halt bit to 0 resumes counting.
- R7: The oscillator-fail flag (minutes bit 7) is 1 after reset. It is set whenever `osc_pulse` has been low for at least 4 consecutive cycles (MISS_LIMIT). Writing minutes with bit 7 = 0 clears it, and writing bit 7 = 1 leaves it unchanged. Detection wins over a clearing write in the same cycle.
- R8: A write (`wr_valid`, addresses 0..6) stores the byte in the register on the next edge, overriding any count for that register. Carries into the other registers that cycle are still taken from the pre-write values. A write to address 7 changes nothing.
- R9: Unused bits always read 0: day of week [7:3], date [7:6] and month [7:5].
- R10: After reset, the registers read seconds 0x00, minutes 0x80, hours 0x00, day of week 0x01, date 0x01, month 0x01 and year 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| osc_pulse | input | 1 | Oscillator pulse seen this cycle |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write byte |
| reg_sec | output | 8 | Halt bit and BCD seconds |
| reg_min | output | 8 | Oscillator-fail flag and BCD minutes |
| reg_hour | output | 8 | Century enable, century, BCD hours |
| reg_dow | output | 8 | Day of week |
| reg_date | output | 8 | BCD date |
| reg_mon | output | 8 | BCD month |
| reg_year | output | 8 | BCD year |

## Verification
A host write and a tick-driven carry can land on the same edge. The write owns the addressed register, while the carry still flows from the old values into the registers above it. The bench provokes this directly by writing seconds while they sit at 59 with a tick present, and randomly through thousands of cycles of overlapping ticks and writes. Every register is compared each cycle against a bench model that applies carries first and writes last. Oscillator-fail detection colliding with a clearing write is covered the same way.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NFIELD = 7;

  typedef enum logic [2:0] {
    A_SEC  = 3'd0,
    A_MIN  = 3'd1,
    A_HOUR = 3'd2,
    A_DOW  = 3'd3,
    A_DATE = 3'd4,
    A_MON  = 3'd5,
    A_YEAR = 3'd6,
    A_NONE = 3'd7
  } cal_addr_e;

  function automatic logic [7:0] field_mask(input int i);
    case (i)
      0, 1:    return 8'h7F;
      2:       return 8'h3F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_min(input int i);
    case (i)
      3, 4, 5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_max(input int i);
    case (i)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return 8'h07;
      4:       return 8'h31;
      5:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int i);
    return field_min(i);
  endfunction

  // Next value of a packed BCD pair; invalid codes are counted from as-is.
  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] mx,
                                          input logic [7:0] mn);
    logic [7:0] r;
    if (v >= mx)            r = mn;
    else if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                    r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // 10 = 2 (mod 4), so divisibility of tens*10+ones needs only two bits.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] m;
    m = {yr[4], 1'b0} + yr[1:0];
    return (m == 2'd0);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    case (mon[4:0])
      5'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MASK = 8'hFF,
  parameter logic [7:0] MINV = 8'h00,
  parameter logic [7:0] RSTV = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic [7:0] max_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] q_o,
  output logic       wrap_o
);
  import rtc_cal_pkg::*;

  logic [7:0] q;
  logic [7:0] nxt;

  assign nxt    = bcd_next(q, max_i, MINV) & MASK;
  assign wrap_o = step_i && (q >= max_i);
  assign q_o    = q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RSTV;
    else if (wr_i)   q <= wr_data_i & MASK;
    else if (step_i) q <= nxt;
  end
endmodule

// File: rtl/rtc_osc_watch.sv
module rtc_osc_watch #(
  parameter int MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic clr_i,
  output logic fail_o
);
  localparam int CW = $clog2(MISS_LIMIT + 1);
  localparam logic [CW-1:0] LIM   = CW'(MISS_LIMIT);
  localparam logic [CW-1:0] LIMM1 = CW'(MISS_LIMIT - 1);

  logic [CW-1:0] miss_q;
  logic          detect;
  logic          flag_q;

  assign detect = !pulse_i && (miss_q >= LIMM1);
  assign fail_o = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            miss_q <= '0;
    else if (pulse_i)      miss_q <= '0;
    else if (miss_q < LIM) miss_q <= miss_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b1;
    else if (detect) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int MISS_LIMIT = 4,
  parameter int ADDR_W     = 3,
  parameter int DW         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              osc_pulse,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     reg_sec,
  output logic [DW-1:0]     reg_min,
  output logic [DW-1:0]     reg_hour,
  output logic [DW-1:0]     reg_dow,
  output logic [DW-1:0]     reg_date,
  output logic [DW-1:0]     reg_mon,
  output logic [DW-1:0]     reg_year
);
  import rtc_cal_pkg::*;

  localparam int SEC = 0, MIN = 1, HR = 2, DOW = 3, DAT = 4, MON = 5, YR = 6;

  logic              wr_fire;
  logic              halt_q, cent_en_q, cent_q, osc_fail;
  logic [NFIELD-1:0] step, wrap, wsel;
  logic [7:0]        fq   [NFIELD];
  logic [7:0]        maxv [NFIELD];

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  // carry chain: hour rollover feeds both day of week and date
  always_comb begin
    step[SEC] = tick_1hz && !halt_q;
    step[MIN] = wrap[SEC];
    step[HR]  = wrap[MIN];
    step[DOW] = wrap[HR];
    step[DAT] = wrap[HR];
    step[MON] = wrap[DAT];
    step[YR]  = wrap[MON];
    for (int i = 0; i < NFIELD; i++) begin
      maxv[i] = (i == DAT) ? month_len(fq[MON], fq[YR]) : field_max(i);
      wsel[i] = wr_fire && (wr_addr == ADDR_W'(i));
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    rtc_bcd_field #(
      .MASK (field_mask(g)),
      .MINV (field_min(g)),
      .RSTV (field_reset(g))
    ) u_fld (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step[g]),
      .max_i     (maxv[g]),
      .wr_i      (wsel[g]),
      .wr_data_i (wr_data[7:0]),
      .q_o       (fq[g]),
      .wrap_o    (wrap[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q    <= 1'b0;
      cent_en_q <= 1'b0;
      cent_q    <= 1'b0;
    end else begin
      if (wsel[SEC]) halt_q <= wr_data[7];
      if (wsel[HR]) begin
        cent_en_q <= wr_data[7];
        cent_q    <= wr_data[6];
      end else if (wrap[YR] && cent_en_q) begin
        cent_q <= !cent_q;
      end
    end
  end

  rtc_osc_watch #(.MISS_LIMIT(MISS_LIMIT)) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (osc_pulse),
    .clr_i   (wsel[MIN] && !wr_data[7]),
    .fail_o  (osc_fail)
  );

  assign reg_sec  = DW'({halt_q, fq[SEC][6:0]});
  assign reg_min  = DW'({osc_fail, fq[MIN][6:0]});
  assign reg_hour = DW'({cent_en_q, cent_q, fq[HR][5:0]});
  assign reg_dow  = DW'(fq[DOW]);
  assign reg_date = DW'(fq[DAT]);
  assign reg_mon  = DW'(fq[MON]);
  assign reg_year = DW'(fq[YR]);

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       osc_pulse,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] reg_sec,
  input logic [7:0] reg_min,
  input logic [7:0] reg_hour,
  input logic [7:0] reg_dow,
  input logic [7:0] reg_date,
  input logic [7:0] reg_mon,
  input logic [7:0] reg_year
);
  logic go, top_of_day;
  assign go         = tick_1hz && !reg_sec[7] && !wr_valid;
  assign top_of_day = reg_sec[6:0] == 7'h59 && reg_min[6:0] == 7'h59 && reg_hour[5:0] == 6'h23;

  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && reg_sec[6:0] == 7'h59) |=> (reg_sec[6:0] == 7'h00));

  p_dow_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && top_of_day && reg_dow == 8'h07) |=> (reg_dow == 8'h01));

  p_date_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && top_of_day && reg_date == 8'h31) |=> (reg_date == 8'h01));

  p_cent_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_hour[7] && !(wr_valid && wr_addr == 3'd2)) |=> $stable(reg_hour[6]));

  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sec[7] && !wr_valid) |=>
      $stable({reg_sec, reg_min[6:0], reg_hour, reg_dow, reg_date, reg_mon, reg_year}));

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_min[7] && !(wr_valid && wr_addr == 3'd1)) |=> reg_min[7]);

  p_wr_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == 3'd0) |=> (reg_sec == $past(wr_data)));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (.*);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 4;

  logic clk = 0, rst_n = 0, tick_1hz = 0, osc_pulse = 1, wr_valid = 0, wr_ready;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] reg_sec, reg_min, reg_hour, reg_dow, reg_date, reg_mon, reg_year;

  int n_chk = 0, n_fail = 0;
  logic [7:0] e [7];
  int miss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core u_rtc_calendar_core (.*);

  function automatic logic [8:0] adv(input logic [7:0] v, input int mx, input int mn, input int msk);
    int lo, hi, r;
    if (v >= mx) return {1'b1, 8'(mn)};
    lo = v % 16; hi = v / 16;
    r = (lo >= 9) ? (hi + 1) * 16 : v + 1;
    return {1'b0, 8'(r & msk)};
  endfunction

  function automatic int mlen(input logic [7:0] m, input logic [7:0] y);
    int yv = (y / 16) * 10 + (y % 16);
    if (m[4:0] == 5'h02) return (yv % 4 == 0) ? 'h29 : 'h28;
    if (m[4:0] == 5'h04 || m[4:0] == 5'h06 || m[4:0] == 5'h09 || m[4:0] == 5'h11) return 'h30;
    return 'h31;
  endfunction

  task automatic check(input string tag);
    logic [7:0] a [7];
    a = '{reg_sec, reg_min, reg_hour, reg_dow, reg_date, reg_mon, reg_year};
    n_chk++;
    for (int i = 0; i < 7; i++)
      if (a[i] !== e[i]) begin
        n_fail++;
        $display("FAIL %s reg%0d actual=%02h expected=%02h", tag, i, a[i], e[i]);
        break;
      end
  endtask

  // one clock: drive at negedge, model the edge, compare after it
  task automatic cyc(input logic t, input logic p, input logic wv, input logic [2:0] ad,
                     input logic [7:0] d, input string tag);
    logic [8:0] r;
    logic [7:0] n [7];
    logic c, det;
    @(negedge clk);
    tick_1hz = t; osc_pulse = p; wr_valid = wv; wr_addr = ad; wr_data = d;
    n = e;
    c = t && !e[0][7];
    if (c) begin r = adv({1'b0, e[0][6:0]}, 'h59, 0, 'h7F); n[0][6:0] = r[6:0]; c = r[8]; end
    if (c) begin r = adv({1'b0, e[1][6:0]}, 'h59, 0, 'h7F); n[1][6:0] = r[6:0]; c = r[8]; end
    if (c) begin r = adv({2'b0, e[2][5:0]}, 'h23, 0, 'h3F); n[2][5:0] = r[5:0]; c = r[8]; end
    if (c) begin r = adv(e[3], 7, 1, 'h07); n[3] = r[7:0]; end
    if (c) begin r = adv(e[4], mlen(e[5], e[6]), 1, 'h3F); n[4] = r[7:0]; c = r[8]; end
    if (c) begin r = adv(e[5], 'h12, 1, 'h1F); n[5] = r[7:0]; c = r[8]; end
    if (c) begin r = adv(e[6], 'h99, 0, 'hFF); n[6] = r[7:0]; c = r[8]; end
    if (c && e[2][7]) n[2][6] = !e[2][6];
    det = !p && (miss >= LIMIT - 1);
    miss = p ? 0 : (miss < LIMIT ? miss + 1 : miss);
    if (wv) case (ad)
      0: n[0] = d;
      1: n[1][6:0] = d[6:0];
      2: n[2] = d;
      3: n[3] = d & 8'h07;
      4: n[4] = d & 8'h3F;
      5: n[5] = d & 8'h1F;
      6: n[6] = d;
      default: ;
    endcase
    if (det) n[1][7] = 1'b1;
    else if (wv && ad == 3'd1 && !d[7]) n[1][7] = 1'b0;
    e = n;
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] d, input string tag);
    cyc(0, 1, 1, ad, d, tag);
  endtask

  task automatic set_all(input logic [7:0] s, mi, h, dw, dt, mo, y, input string tag);
    wr(0, s, tag); wr(1, mi, tag); wr(2, h, tag); wr(3, dw, tag);
    wr(4, dt, tag); wr(5, mo, tag); wr(6, y, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    e = '{8'h00, 8'h80, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1; check("R10 reset values");

    // R1 plain carries
    set_all(8'h58, 8'h59, 8'h12, 8'h02, 8'h10, 8'h05, 8'h20, "R8 setup");
    cyc(1, 1, 0, 0, 0, "R1 sec 58->59");
    cyc(1, 1, 0, 0, 0, "R1 sec/min rollover into hour");
    // R3 leap and non-leap Feb, 30-day month, December
    set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h03, "R3 setup");
    cyc(1, 1, 0, 0, 0, "R3 Feb 28 non-leap -> Mar 01");
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h04, "R3 setup");
    cyc(1, 1, 0, 0, 0, "R3 Feb 28 leap -> 29, R2 dow 7->1");
    cyc(0, 1, 1, 3, 8'hF8, "R9 reserved dow bits");
    cyc(0, 1, 1, 0, 8'h59, "R8 setup"); cyc(0, 1, 1, 1, 8'h59, "R8 setup");
    cyc(0, 1, 1, 2, 8'h23, "R8 setup");
    cyc(1, 1, 0, 0, 0, "R3 Feb 29 leap -> Mar 01, R2 dow 0->1");
    set_all(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h11, 8'h50, "R3 setup");
    cyc(1, 1, 0, 0, 0, "R3 30-day month wrap");
    // R4 century
    set_all(8'h59, 8'h59, 8'hA3, 8'h01, 8'h31, 8'h12, 8'h99, "R4 setup");
    cyc(1, 1, 0, 0, 0, "R4 year 99->00 toggles century when enabled");
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99, "R4 setup");
    cyc(1, 1, 0, 0, 0, "R4 century held when disabled");
    // R5 invalid codes
    wr(0, 8'h7A, "R5 setup"); cyc(1, 1, 0, 0, 0, "R5 invalid sec rolls with carry");
    wr(0, 8'h3C, "R5 setup"); cyc(1, 1, 0, 0, 0, "R5 invalid low digit -> tens+1");
    wr(4, 8'h3F, "R9 date mask"); wr(5, 8'hFF, "R9 month mask");
    // R6 halt
    wr(0, 8'hA5, "R6 halt set");
    repeat (3) cyc(1, 1, 0, 0, 0, "R6 ticks ignored while halted");
    wr(0, 8'h25, "R6 resume"); cyc(1, 1, 0, 0, 0, "R6 counting resumed");
    // R7 oscillator fail
    wr(1, 8'h10, "R7 clear");
    repeat (3) cyc(0, 0, 0, 0, 0, "R7 three misses keep flag clear");
    cyc(0, 1, 0, 0, 0, "R7 pulse resets run");
    repeat (4) cyc(0, 0, 0, 0, 0, "R7 fourth miss sets flag");
    cyc(0, 0, 1, 1, 8'h00, "R7 detect beats clearing write");
    cyc(0, 1, 1, 1, 8'h00, "R7 write 0 clears");
    cyc(0, 1, 1, 1, 8'h80, "R7 write 1 no effect");
    // R8 collision and dead address
    wr(0, 8'h59, "R8 setup");
    cyc(1, 1, 1, 0, 8'h30, "R8 write wins, carry from old seconds");
    cyc(0, 1, 1, 7, 8'hFF, "R8 address 7 ignored");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      if (a == 0 && $urandom_range(0, 3) != 0) d[7] = 1'b0;
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 9) > 1),
          1'($urandom_range(0, 9) == 0), a, d, "R1/R8 random");
      if (k % 400 == 0) set_all(8'h57, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h99, "R3 random setup");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule